// File: doc/BRIEF.md
# Nibble Expression Stack

This block is the data stack of a 4-bit stack-oriented processor. The topmost nibble lives in a dedicated register so that an ALU can reach it without a memory access. Every item beneath it sits in a 256 x 4 RAM. An 8-bit pointer addresses the second item, not the top one. The RAM has one write port and one asynchronous read port. The read port always points at the second item, so the top two items are visible at the outputs at all times.

A control interface issues one request per clock: push a nibble, pop, replace the top, or load the pointer. A push first advances the pointer, then saves the old top at the new address, and the pushed nibble becomes the new top. A pop copies the second item into the top register, then moves the pointer back. Pointer arithmetic wraps modulo 256. The pointer holds no meaningful base after reset, so software loads it before it uses the stack. For a deterministic start, both registers clear to zero.

Top module: `nibble_stack`

## Requirements
- R1: While rst_ni is low, and after its release with no request, tos_o reads 0 and sp_o reads 0.
- R2: A push alone (push_i=1, pop_i=0, ld_sp_i=0) makes sp_o one higher on the next cycle. nos_o then shows the previous tos_o, and tos_o shows push_data_i.
- R3: A pop alone (pop_i=1, push_i=0, ld_sp_i=0) makes tos_o equal the previous nos_o on the next cycle, and sp_o one lower.
- R4: ld_sp_i=1 loads sp_i into the pointer and leaves tos_o and the RAM unchanged. It takes priority over push_i and pop_i asserted in the same cycle.
- R5: push_i and pop_i together, with ld_sp_i low, replace the top: tos_o takes push_data_i, while sp_o and the RAM stay unchanged.
- R6: Pointer arithmetic wraps modulo 256. A push at 255 gives 0, and a pop at 0 gives 255. No flag is raised.
- R7: With no request, tos_o, sp_o and nos_o hold their values.
- R8: nos_o always equals the RAM nibble at address sp_o, including right after a pointer load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| ld_sp_i | input | 1 | Load-pointer request |
| push_data_i | input | 4 | Nibble to push or to replace the top with |
| sp_i | input | 8 | Value for a pointer load |
| tos_o | output | 4 | Top of stack |
| nos_o | output | 4 | Second item (RAM at sp_o) |
| sp_o | output | 8 | Current stack pointer |

## Verification
The in-RTL assertions check the one-cycle effect of every request on every cycle. These effects are the pointer step and the top/second transfer on push and pop, load priority, replace and idle hold. They also cover the pointer wrap, because the assertions use 8-bit arithmetic. Only the bench scenarios show that RAM contents survive whole push/pop runs. The bench fills all 256 locations, sweeps the pointer across every address to read back each saved nibble, and then runs long pseudo-random push/pop/replace sequences. It checks every step against a reference model.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_REPL,
    OP_PUSH,
    OP_POP
  } stack_op_e;
endpackage

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              ld_sp_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] sp_q_i,
  input  logic [DATA_W-1:0] tos_q_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] sp_d_o,
  output logic [DATA_W-1:0] tos_d_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  stack_op_e op;

  // load beats everything; push+pop is a replace
  always_comb begin
    if (ld_sp_i)               op = OP_LOAD;
    else if (push_i && pop_i)  op = OP_REPL;
    else if (push_i)           op = OP_PUSH;
    else if (pop_i)            op = OP_POP;
    else                       op = OP_IDLE;
  end

  logic [ADDR_W-1:0] sp_inc, sp_dec;
  assign sp_inc = sp_q_i + ADDR_W'(1);
  assign sp_dec = sp_q_i - ADDR_W'(1);

  always_comb begin
    sp_d_o  = sp_q_i;
    tos_d_o = tos_q_i;
    we_o    = 1'b0;
    waddr_o = sp_inc;
    wdata_o = tos_q_i;
    unique case (op)
      OP_LOAD: sp_d_o = sp_i;
      OP_REPL: tos_d_o = push_data_i;
      OP_PUSH: begin
        sp_d_o  = sp_inc;
        tos_d_o = push_data_i;
        we_o    = 1'b1;
      end
      OP_POP: begin
        tos_d_o = rd_data_i;
        sp_d_o  = sp_dec;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nibble_stack.sv
module nibble_stack #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              ld_sp_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [DATA_W-1:0] nos_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic [ADDR_W-1:0] sp_q, sp_d, waddr;
  logic [DATA_W-1:0] tos_q, tos_d, wdata, rdata;
  logic              we;

  stack_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .push_i      (push_i),
    .pop_i       (pop_i),
    .ld_sp_i     (ld_sp_i),
    .push_data_i (push_data_i),
    .sp_i        (sp_i),
    .sp_q_i      (sp_q),
    .tos_q_i     (tos_q),
    .rd_data_i   (rdata),
    .sp_d_o      (sp_d),
    .tos_d_o     (tos_d),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata)
  );

  stack_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (sp_q),
    .rdata_o (rdata)
  );

  // pointer has no defined base until loaded; zero keeps it deterministic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      tos_q <= '0;
    end else begin
      sp_q  <= sp_d;
      tos_q <= tos_d;
    end
  end

  assign tos_o = tos_q;
  assign nos_o = rdata;
  assign sp_o  = sp_q;

  logic push_only, pop_only, repl, idle;
  assign push_only = push_i && !pop_i && !ld_sp_i;
  assign pop_only  = pop_i && !push_i && !ld_sp_i;
  assign repl      = push_i && pop_i && !ld_sp_i;
  assign idle      = !push_i && !pop_i && !ld_sp_i;

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (tos_o == '0 && sp_o == '0));

  assert_push_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_only |=> (sp_o == $past(sp_o) + ADDR_W'(1)) && (tos_o == $past(push_data_i)));

  assert_push_save_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_only |=> nos_o == $past(tos_o));

  assert_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_only |=> (tos_o == $past(nos_o)) && (sp_o == $past(sp_o) - ADDR_W'(1)));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sp_i |=> (sp_o == $past(sp_i)) && $stable(tos_o));

  assert_replace_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl |=> $stable(sp_o) && $stable(nos_o) && (tos_o == $past(push_data_i)));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(sp_o) && $stable(tos_o) && $stable(nos_o));
endmodule

// File: tb/nibble_stack_test.sv
module nibble_stack_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, ld_sp_i = 1'b0;
  logic [3:0] push_data_i = '0;
  logic [7:0] sp_i = '0;
  logic [3:0] tos_o, nos_o;
  logic [7:0] sp_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_stack uut (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .ld_sp_i(ld_sp_i), .push_data_i(push_data_i), .sp_i(sp_i),
    .tos_o(tos_o), .nos_o(nos_o), .sp_o(sp_o)
  );

  int checks = 0;
  int errors = 0;

  logic [3:0] m_mem [256];
  bit         m_val [256];
  logic [3:0] m_tos = '0;
  logic [7:0] m_sp = '0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "tos", tos_o, m_tos);
    check(req, "sp", sp_o, m_sp);
    if (m_val[m_sp]) check(req, "nos", nos_o, m_mem[m_sp]);
  endtask

  task automatic step(input bit pu, input bit po, input bit ld, input logic [7:0] v,
                      input logic [3:0] d, input string req);
    @(negedge clk);
    push_i = pu; pop_i = po; ld_sp_i = ld; sp_i = v; push_data_i = d;
    @(posedge clk);
    #1;
    push_i = 0; pop_i = 0; ld_sp_i = 0;
    if (ld) m_sp = v;
    else if (pu && po) m_tos = d;
    else if (pu) begin
      m_sp = m_sp + 8'd1;
      m_mem[m_sp] = m_tos;
      m_val[m_sp] = 1'b1;
      m_tos = d;
    end else if (po) begin
      m_tos = m_mem[m_sp];
      m_sp = m_sp - 8'd1;
    end
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 256; i++) m_val[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "tos in reset", tos_o, 0);
    check("R1", "sp in reset", sp_o, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1", "tos after reset", tos_o, 0);
    check("R1", "sp after reset", sp_o, 0);

    step(0, 0, 1, 8'd255, 4'd0, "R4");
    step(0, 0, 0, 8'd0, 4'd0, "R7");
    // R6: first push wraps 255 -> 0; fills all 256 locations
    for (int i = 0; i < 256; i++)
      step(1, 0, 0, 8'd0, 4'((i * 7 + 3) & 15), (i == 0) ? "R6" : "R2");
    // R8: nos follows sp through every address
    for (int a = 0; a < 256; a++)
      step(0, 0, 1, 8'(a), 4'd0, "R8");
    step(0, 0, 1, 8'd4, 4'd0, "R4");
    // R3 pops, crossing 0 -> 255 (R6)
    for (int i = 0; i < 10; i++)
      step(0, 1, 0, 8'd0, 4'd0, (i == 4) ? "R6" : "R3");
    step(1, 1, 0, 8'd0, 4'd9, "R5");
    step(1, 1, 0, 8'd0, 4'd2, "R5");
    step(1, 1, 1, 8'd130, 4'd15, "R4");
    step(1, 0, 1, 8'd17, 4'd11, "R4");
    step(0, 1, 1, 8'd200, 4'd6, "R4");
    step(0, 0, 0, 8'd0, 4'd0, "R7");

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      bit pu, po;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pu = lfsr[0];
      po = lfsr[1];
      if (pu && po) step(1, 1, lfsr[2] & lfsr[3] & lfsr[4], lfsr[11:4], lfsr[7:4], "R5");
      else if (pu) step(1, 0, 0, 8'd0, lfsr[7:4], "R2");
      else if (po) step(0, 1, 0, 8'd0, 4'd0, "R3");
      else step(0, 0, 0, 8'd0, 4'd0, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule